// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer with Input Capture

This block is one timer channel. A 32-bit counter steps downward once per count event, and a constant register supplies the value it reloads. The count event comes from one of seven sources, chosen by a control field. Five of them are taps of a free-running prescaler on the peripheral clock, dividing by 4, 16, 64, 256 and 1024. The sixth is an edge on an external pin, after a synchronizer, and a control bit picks the rising or the falling edge. The seventh is a slow real-time tick.

When the counter reaches zero, the next count event loads the constant value instead of wrapping, and it sets a sticky underflow flag. As a separate function, the same external pin edge can latch the current counter value into a capture register. A capture sets its own sticky flag and sends a single-cycle request to a DMA controller. Each flag reaches its interrupt output only when its enable bit is set. Software clears a flag by writing 0 to it.

A small control state machine gates counting. It has three states. STOP is entered on reset or when the start bit is 0. RUN means counting is allowed. SLEEP is entered while the standby input is high and the source is not the real-time tick. The transitions are:
- START: STOP to RUN, or STOP to SLEEP when standby is already high.
- HALT: RUN or SLEEP to STOP when start is 0.
- DOZE: RUN to SLEEP.
- WAKE: SLEEP to RUN.

The state changes one clock after the inputs that cause it.

Top module: `reload_timer`

## Requirements
- R1: After reset the constant, counter, control and capture registers read 0, and irq_underflow, irq_capture and dma_req are low.
- R2: Software can write and read back, at any time, the constant register (address 0) and the counter (address 1). The control register is at address 2. The capture register is at address 3 and can only be read.
- R3: Control bits [2:0] select the source. Codes 0 to 4 give one decrement every 4, 16, 64, 256 and 1024 clock cycles respectively. Code 7 gives no count.
- R4: Source code 5 counts synchronized edges of ext_pin. Control bit 3 picks the edge: 0 for rising, 1 for falling.
- R5: Source code 6 decrements the counter once for each single-cycle pulse on rtc_tick.
- R6: A count event at counter value 0 loads the constant register, not all ones, and sets the underflow flag (control bit 8).
- R7: irq_underflow is high exactly when the underflow flag and its enable (control bit 5) are both 1.
- R8: Both flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R9: While the start bit (control bit 4) is 0, count events do not change the counter.
- R10: While standby is high, only source code 6 keeps counting. The other sources hold the counter.
- R11: When capture is enabled (control bit 6), an active ext_pin edge, chosen by bit 3, copies the counter into the capture register and sets the capture flag (bit 9). irq_capture is high when bit 9 and its enable (bit 7) are both 1.
- R12: Each capture produces a dma_req pulse exactly one cycle wide, in the cycle after the capture.
- R13: A counter write and a count event in the same cycle leave the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| standby | input | 1 | Module standby request |
| rtc_tick | input | 1 | Slow real-time tick, one cycle wide |
| ext_pin | input | 1 | External clock / capture pin, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | CNT_W | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | CNT_W | Read data |
| irq_underflow | output | 1 | Underflow interrupt |
| irq_capture | output | 1 | Capture interrupt |
| dma_req | output | 1 | Data-transfer request pulse |

## Verification
The bench builds the block with its default values: a 32-bit counter and a two-flop synchronizer. These values let it observe the full 1024-cycle period of the slowest prescaler tap within its run. They also let it tell a 0-to-reload step apart from a wrap to 0xFFFFFFFF. A vector table measures the decrement period of each prescaler tap. Directed tests then cover the following:
- rising and falling external edges, for both counting and capture;
- standby with a prescaler source and with the tick source;
- flag clearing;
- a counter write that coincides with a count event.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int N_TAPS = 5;

    typedef enum logic [2:0] {
        SRC_DIV4    = 3'd0,
        SRC_DIV16   = 3'd1,
        SRC_DIV64   = 3'd2,
        SRC_DIV256  = 3'd3,
        SRC_DIV1024 = 3'd4,
        SRC_EXT     = 3'd5,
        SRC_RTC     = 3'd6,
        SRC_OFF     = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } run_e;

    localparam logic [1:0] A_CONST = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;
    localparam logic [1:0] A_CAPT  = 2'd3;

    localparam int B_FALL  = 3;
    localparam int B_START = 4;
    localparam int B_UFIE  = 5;
    localparam int B_CAPEN = 6;
    localparam int B_CAPIE = 7;
    localparam int B_UFF   = 8;
    localparam int B_CAPF  = 9;
endpackage

// File: rtl/rt_prescale.sv
module rt_prescale #(
    parameter int TAPS  = 5,
    localparam int PRE_W = 2 * TAPS
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] tap
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Tap k fires once every 4^(k+1) cycles, when its low bits are zero.
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign tap[k] = (pre_q[2*k+1:0] == '0);
    end
endmodule

// File: rtl/rt_edge.sv
module rt_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // SYNC_N synchronizer flops plus one history flop.
    logic [SYNC_N:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_N-1:0], pin};
    end

    assign rise =  sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
    assign fall = ~sh_q[SYNC_N-1] &  sh_q[SYNC_N];
endmodule

// File: rtl/rt_core.sv
module rt_core import rt_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hold,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             dec_go,
    output logic             underflow
);
    run_e state_q, state_d;
    logic run;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // Transitions: START, HALT, DOZE, WAKE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (start)     state_d = hold ? ST_SLEEP : ST_RUN;
            ST_RUN:   if (!start)    state_d = ST_STOP;
                      else if (hold) state_d = ST_SLEEP;
            ST_SLEEP: if (!start)    state_d = ST_STOP;
                      else if (!hold) state_d = ST_RUN;
            default:                 state_d = ST_STOP;
        endcase
    end

    // Outputs
    always_comb begin
        run       = (state_q == ST_RUN);
        dec_go    = run & tick & ~ld;
        underflow = dec_go & (cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (ld)        cnt <= ld_val;
        else if (underflow) cnt <= reload;
        else if (dec_go)    cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/reload_timer.sv
module reload_timer import rt_pkg::*; #(
    parameter int CNT_W  = 32,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             rtc_tick,
    input  logic             ext_pin,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic [1:0]       bus_raddr,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_underflow,
    output logic             irq_capture,
    output logic             dma_req
);
    logic [N_TAPS-1:0] tap;
    logic              rise, fall, ext_ev, tick, hold, cap_go;
    logic [7:0]        ctrl_q;
    logic [7:0]        src_vec;
    logic              uf_flag, cap_flag, dma_q;
    logic [CNT_W-1:0]  reload_q, cnt_q, cap_q;
    logic              dec_go, underflow, cnt_wr, ctrl_wr;
    logic              uf_clr, cap_clr;
    src_e              src;

    rt_prescale #(.TAPS(N_TAPS)) u_pre (
        .clk(clk), .rst_n(rst_n), .tap(tap)
    );

    rt_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(rise), .fall(fall)
    );

    assign src     = src_e'(ctrl_q[2:0]);
    assign ext_ev  = ctrl_q[B_FALL] ? fall : rise;
    assign src_vec = {1'b0, rtc_tick, ext_ev, tap};
    assign tick    = src_vec[ctrl_q[2:0]];
    assign hold    = standby && (src != SRC_RTC);
    assign cap_go  = ctrl_q[B_CAPEN] & ext_ev;
    assign cnt_wr  = bus_wr && (bus_addr == A_COUNT);
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign uf_clr  = ctrl_wr && !bus_wdata[B_UFF];
    assign cap_clr = ctrl_wr && !bus_wdata[B_CAPF];

    rt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(ctrl_q[B_START]), .hold(hold),
        .tick(tick), .ld(cnt_wr), .ld_val(bus_wdata), .reload(reload_q),
        .cnt(cnt_q), .dec_go(dec_go), .underflow(underflow)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
            uf_flag  <= 1'b0;
            cap_flag <= 1'b0;
            cap_q    <= '0;
            dma_q    <= 1'b0;
        end else begin
            if (bus_wr && (bus_addr == A_CONST)) reload_q <= bus_wdata;
            if (ctrl_wr) ctrl_q <= bus_wdata[7:0];
            // A new event wins over a clear in the same cycle.
            uf_flag  <= underflow | (uf_flag & ~uf_clr);
            cap_flag <= cap_go | (cap_flag & ~cap_clr);
            if (cap_go) cap_q <= cnt_q;
            dma_q <= cap_go;
        end
    end

    always_comb begin
        unique case (bus_raddr)
            A_CONST: bus_rdata = reload_q;
            A_COUNT: bus_rdata = cnt_q;
            A_CTRL:  bus_rdata = CNT_W'({cap_flag, uf_flag, ctrl_q});
            default: bus_rdata = cap_q;
        endcase
    end

    assign irq_underflow = uf_flag & ctrl_q[B_UFIE];
    assign irq_capture   = cap_flag & ctrl_q[B_CAPIE];
    assign dma_req       = dma_q;
endmodule

// File: rtl/rt_timer_chk.sv
module rt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             dec_go,
    input logic             start,
    input logic             uf_flag,
    input logic             uf_clr,
    input logic             cap_go,
    input logic             cap_flag,
    input logic             dma_req
);
    a_r13_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(wdata));

    a_r6_underflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_go && cnt == '0) |=> (cnt == $past(reload)) && uf_flag);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !uf_clr) |=> uf_flag);

    a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !start ##1 !cnt_wr |=> $stable(cnt));

    a_r11_capture_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cap_go |=> cap_flag);

    a_r12_dma_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cap_go |=> dma_req);

    a_r12_dma_single: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);
endmodule

bind reload_timer rt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(bus_wdata),
    .cnt(cnt_q), .reload(reload_q), .dec_go(dec_go), .start(ctrl_q[4]),
    .uf_flag(uf_flag), .uf_clr(uf_clr), .cap_go(cap_go),
    .cap_flag(cap_flag), .dma_req(dma_req)
);

// File: tb/test_reload_timer.sv
module test_reload_timer;
    localparam int W = 32;
    // source code, expected decrement period
    localparam int VEC [5][2] = '{'{0, 4}, '{1, 16}, '{2, 64}, '{3, 256}, '{4, 1024}};

    logic clk = 0, rst_n = 0, standby = 0, rtc_tick = 0, ext_pin = 0;
    logic bus_wr = 0;
    logic [1:0] bus_addr = 0, bus_raddr = 0;
    logic [W-1:0] bus_wdata = 0, bus_rdata;
    logic irq_underflow, irq_capture, dma_req;
    int checks = 0, errors = 0, dma_cnt = 0;

    always #5 clk = ~clk;

    reload_timer i_reload_timer (
        .clk(clk), .rst_n(rst_n), .standby(standby), .rtc_tick(rtc_tick),
        .ext_pin(ext_pin), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .irq_underflow(irq_underflow), .irq_capture(irq_capture), .dma_req(dma_req)
    );

    always @(posedge clk) if (dma_req) dma_cnt++;

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        @(negedge clk); bus_raddr = a; #1; v = bus_rdata;
    endtask

    // ctrl word: flag bits 8/9 written as 1 keep the flags
    function automatic logic [W-1:0] cw(int src, bit fl, bit st, bit uie, bit cen, bit cie);
        return W'({2'b11, cie, cen, uie, st, fl, 3'(src)});
    endfunction

    task automatic pulse_rtc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rtc_tick = 1;
            @(negedge clk); rtc_tick = 0;
        end
    endtask

    task automatic pin_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_pin = ~ext_pin; repeat (4) @(negedge clk);
            ext_pin = ~ext_pin; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic done;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        done();
    end

    initial begin
        logic [W-1:0] v, a, prev;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin rd(2'(i), v); chk("R1 reg reset", v, 0); end
        chk("R1 outputs reset", W'({irq_underflow, irq_capture, dma_req}), 0);

        // R2 read/write
        wr(0, 32'h1234_5678); rd(0, v); chk("R2 constant", v, 32'h1234_5678);
        wr(1, 32'hCAFE_0000); rd(1, v); chk("R2 counter", v, 32'hCAFE_0000);

        // R3 prescaler table
        for (int i = 0; i < 5; i++) begin
            int n;
            wr(1, 32'h1000); wr(2, cw(VEC[i][0], 0, 1, 0, 0, 0));
            rd(1, prev); n = 0;
            while (n < 5000) begin rd(1, v); n++; if (v != prev) break; end
            prev = v; n = 0;
            while (n < 5000) begin rd(1, v); n++; if (v != prev) break; end
            chk($sformatf("R3 period src %0d", VEC[i][0]), W'(n), W'(VEC[i][1]));
        end
        wr(2, cw(7, 0, 1, 0, 0, 0)); rd(1, a); repeat (50) @(negedge clk); rd(1, v);
        chk("R3 source off", v, a);

        // R5 rtc tick source
        wr(1, 100); wr(2, cw(6, 0, 1, 0, 0, 0)); pulse_rtc(7); rd(1, v);
        chk("R5 rtc ticks", v, 93);

        // R9 start=0 blocks counting
        wr(2, cw(6, 0, 0, 0, 0, 0)); repeat (2) @(negedge clk); pulse_rtc(5); rd(1, v);
        chk("R9 stopped", v, 93);

        // R4 external edges
        wr(1, 50); wr(2, cw(5, 0, 1, 0, 0, 0)); pin_pulse(3); rd(1, v);
        chk("R4 rising edges", v, 47);
        wr(2, cw(5, 1, 1, 0, 0, 0)); pin_pulse(2); rd(1, v);
        chk("R4 falling edges", v, 45);

        // R6 underflow to reload, R7 gating, R8 sticky
        wr(0, 5); wr(1, 2); wr(2, cw(6, 0, 1, 0, 0, 0)); pulse_rtc(2);
        rd(1, v); chk("R6 reaches zero", v, 0);
        rd(2, v); chk("R6 no flag at zero", W'(v[8]), 0);
        pulse_rtc(1); rd(1, v); chk("R6 reload not wrap", v, 5);
        rd(2, v); chk("R6 flag set", W'(v[8]), 1);
        chk("R7 irq masked", W'(irq_underflow), 0);
        wr(2, cw(6, 0, 1, 1, 0, 0)); @(negedge clk); chk("R7 irq enabled", W'(irq_underflow), 1);
        pulse_rtc(1); rd(2, v); chk("R8 flag sticky", W'(v[8]), 1);
        wr(2, cw(6, 0, 1, 1, 0, 0) & ~32'h100); rd(2, v);
        chk("R8 flag cleared", W'(v[8]), 0); chk("R8 irq dropped", W'(irq_underflow), 0);

        // R10 standby
        standby = 1;
        wr(1, 200); wr(2, cw(0, 0, 1, 0, 0, 0)); repeat (5) @(negedge clk);
        rd(1, a); repeat (100) @(negedge clk); rd(1, v); chk("R10 standby holds div4", v, a);
        wr(2, cw(6, 0, 1, 0, 0, 0)); repeat (2) @(negedge clk); pulse_rtc(3); rd(1, v);
        chk("R10 standby rtc counts", v, a - 3);
        standby = 0;

        // R11/R12 capture rising
        wr(2, cw(6, 0, 0, 0, 1, 1)); wr(1, 32'h55AA); pin_pulse(1);
        rd(3, v); chk("R11 capture value", v, 32'h55AA);
        rd(2, v); chk("R11 capture flag", W'(v[9]), 1);
        chk("R11 capture irq", W'(irq_capture), 1);
        chk("R12 one dma pulse", W'(dma_cnt), 1);
        // falling selected: rising edge ignored, falling captures
        wr(2, cw(6, 1, 0, 0, 1, 1) & ~32'h200); wr(1, 32'h1111);
        @(negedge clk); ext_pin = 1; repeat (8) @(negedge clk);
        rd(3, v); chk("R11 rising ignored", v, 32'h55AA);
        rd(2, v); chk("R11 flag stays clear", W'(v[9]), 0);
        ext_pin = 0; repeat (8) @(negedge clk);
        rd(3, v); chk("R11 falling capture", v, 32'h1111);
        chk("R12 second dma pulse", W'(dma_cnt), 2);

        // R13 write beats count
        wr(2, cw(6, 0, 1, 0, 0, 0)); wr(1, 10); repeat (2) @(negedge clk);
        @(negedge clk); bus_wr = 1; bus_addr = 1; bus_wdata = 77; rtc_tick = 1;
        @(negedge clk); bus_wr = 0; rtc_tick = 0;
        rd(1, v); chk("R13 write wins", v, 77);

        done();
    end
endmodule